// File: doc/BRIEF.md
# Prioritised Interrupt Pending and Service Controller

This block keeps the interrupt bookkeeping for a small set of event sources (by default five: three counter/timers and two ports). Every source owns a pending flag, an in-service flag, an enable flag and an overrun flag. Software changes the first three through a 3-bit coded command aimed at one source. Hardware events raise the pending flag. A fixed priority chain decides which pending, enabled source may interrupt. The shared active-low request line is gated by a master enable.

Sources are numbered in priority order, index 0 highest: 0 = counter/timer 3, 1 = port A, 2 = counter/timer 2, 3 = port B, 4 = counter/timer 1. Each source has a writable base vector. A vector read returns that base. The two low bits may be replaced by live status. A current-vector output always shows the vector of the present winner. An acknowledge strobe marks the winner as in service and returns its vector in the same cycle.

Top module: `icu_top`

## Requirements
- R1: A command (`cmd_valid` high) applies to source `cmd_sel` at the next clock edge, with `cmd_code` meaning: 0 nothing, 1 clear pending and in-service, 2 set in-service, 3 clear in-service, 4 set pending, 5 clear pending, 6 set enable, 7 clear enable.
- R2: A pulse on `src_event[i]` sets pending for source i. If pending was already set, it also sets that source's overrun flag. Codes 1 and 5 clear the overrun flag. A clearing command wins over an event in the same cycle.
- R3: Source i requests when pending and enable are both 1 and no source with index less than or equal to i has in-service set. Among requesting sources the lowest index wins.
- R4: `irq_n` is registered. It is low one cycle after a state in which the master enable is 1 and some source requests. Otherwise it is high.
- R5: `cur_vec` is combinational. It is the winner's vector, formed as in R6, or all ones when no source requests.
- R6: A read (`vec_rd`) of source `vec_rsel` shows on `vec_rdata` after the next edge. If the master enable and that source's status bit are both 1, bits 1 and 0 are replaced by {overrun, pending}. Otherwise the unmodified base is returned.
- R7: The control register has bit 0 = soft reset, bit i+1 = status-include for source i, and the top bit = master enable. Hardware reset leaves it reading 1. Writing bit 0 = 1 makes it read 1. While bit 0 is 1, a write only updates bit 0 and the other bits stay 0.
- R8: An `ack` while a source requests sets that source's in-service flag at the edge. During the ack cycle `cur_vec` shows that source's vector. An ack with no requester has no effect.
- R9: While soft reset is set (or being written), all per-source flags are held at 0, and events and commands are ignored.
- R10: `vec_wr` loads `vec_wdata` as the base vector of `vec_wsel`. Bases reset to 0 on hardware reset and are kept through soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_event | input | NUM_SRC | Per-source event pulses |
| cmd_valid | input | 1 | Command strobe |
| cmd_sel | input | SEL_W | Command target source |
| cmd_code | input | 3 | Command code (R1) |
| ack | input | 1 | Interrupt acknowledge strobe |
| ctl_wr | input | 1 | Control register write |
| ctl_wdata | input | NUM_SRC+2 | Control write data |
| ctl_rdata | output | NUM_SRC+2 | Control register contents |
| vec_wr | input | 1 | Base vector write |
| vec_wsel | input | SEL_W | Base vector write target |
| vec_wdata | input | VEC_W | Base vector write data |
| vec_rd | input | 1 | Vector read strobe |
| vec_rsel | input | SEL_W | Vector read target |
| vec_rdata | output | VEC_W | Registered vector read result |
| cur_vec | output | VEC_W | Vector of the current winner, or all ones |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The bench targets the cases where ordering matters.

- A second event while pending must raise the overrun bit; a design that misses this shows status 01 instead of 11.
- An in-service source must block itself and all lower sources; a design that blocks only strictly higher ones would keep `irq_n` low after acknowledge.
- An event and a pending-clear in the same cycle must leave pending clear; the wrong order would present that source's vector.
- Master enable off must return the raw base and hold `irq_n` high.
- Soft reset must swallow events and control writes; a leaky design would show a stale pending source or a non-zero control value after release.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_CLR_BOTH = 3'd1,
    CMD_SET_IUS  = 3'd2,
    CMD_CLR_IUS  = 3'd3,
    CMD_SET_IP   = 3'd4,
    CMD_CLR_IP   = 3'd5,
    CMD_SET_IE   = 3'd6,
    CMD_CLR_IE   = 3'd7
  } icu_cmd_e;

  localparam int STAT_W = 2;

endpackage

// File: rtl/icu_src_cell.sv
module icu_src_cell
  import icu_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     event_i,
  input  logic     cmd_hit,
  input  icu_cmd_e cmd_code,
  input  logic     ack_hit,
  output logic     ip,
  output logic     ius,
  output logic     ie,
  output logic     err
);

  logic ip_n, ius_n, ie_n, err_n;

  always_comb begin
    ip_n  = ip;
    ius_n = ius;
    ie_n  = ie;
    err_n = err;
    if (event_i) begin
      if (ip) err_n = 1'b1;
      ip_n = 1'b1;
    end
    if (cmd_hit) begin
      case (cmd_code)
        CMD_CLR_BOTH: begin ip_n = 1'b0; ius_n = 1'b0; err_n = 1'b0; end
        CMD_SET_IUS:  ius_n = 1'b1;
        CMD_CLR_IUS:  ius_n = 1'b0;
        CMD_SET_IP:   ip_n = 1'b1;
        CMD_CLR_IP:   begin ip_n = 1'b0; err_n = 1'b0; end
        CMD_SET_IE:   ie_n = 1'b1;
        CMD_CLR_IE:   ie_n = 1'b0;
        default:      ;
      endcase
    end
    if (ack_hit) ius_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ip  <= 1'b0;
      ius <= 1'b0;
      ie  <= 1'b0;
      err <= 1'b0;
    end else begin
      ip  <= ip_n;
      ius <= ius_n;
      ie  <= ie_n;
      err <= err_n;
    end
  end

  // R1: a pending-clear command leaves pending low
  a_r1_clear_ip: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && cmd_code == CMD_CLR_IP) |=> !ip);

  // R1: an enable-set command outside soft reset takes effect
  a_r1_set_ie: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && cmd_code == CMD_SET_IE && !clr) |=> ie);

  // R2: overrun only ever appears alongside pending
  a_r2_err_with_ip: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ip);

endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
  parameter int N     = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     ip,
  input  logic [N-1:0]     ie,
  input  logic [N-1:0]     ius,
  output logic [N-1:0]     win,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_any
);

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    win     = '0;
    win_idx = '0;
    win_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      blocked = blocked | ius[i];
      if (ip[i] && ie[i] && !blocked && !win_any) begin
        win[i]  = 1'b1;
        win_idx = IDX_W'(i);
        win_any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/icu_vec_bank.sv
module icu_vec_bank #(
  parameter int N     = 5,
  parameter int VEC_W = 8,
  parameter int SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [VEC_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel_a,
  output logic [VEC_W-1:0] rd_data_a,
  input  logic [SEL_W-1:0] rd_sel_b,
  output logic [VEC_W-1:0] rd_data_b
);

  logic [VEC_W-1:0] base_q [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst)
          base_q[g] <= '0;
        else if (wr_en && wr_sel == SEL_W'(g))
          base_q[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel_a == SEL_W'(i)) rd_data_a = base_q[i];
      if (rd_sel_b == SEL_W'(i)) rd_data_b = base_q[i];
    end
  end

endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int VEC_W   = 8,
  parameter int SEL_W   = $clog2(NUM_SRC),
  parameter int CTL_W   = NUM_SRC + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic               cmd_valid,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic [2:0]         cmd_code,
  input  logic               ack,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic [CTL_W-1:0]   ctl_rdata,
  input  logic               vec_wr,
  input  logic [SEL_W-1:0]   vec_wsel,
  input  logic [VEC_W-1:0]   vec_wdata,
  input  logic               vec_rd,
  input  logic [SEL_W-1:0]   vec_rsel,
  output logic [VEC_W-1:0]   vec_rdata,
  output logic [VEC_W-1:0]   cur_vec,
  output logic               irq_n
);

  localparam int MIE_BIT = CTL_W - 1;

  logic [CTL_W-1:0]   ctl_q;
  logic               clr, mie;
  logic [NUM_SRC-1:0] vis;
  logic [NUM_SRC-1:0] ip_v, ius_v, ie_v, err_v, win;
  logic [SEL_W-1:0]   win_idx;
  logic               win_any;
  logic [VEC_W-1:0]   base_rd, base_cur;

  function automatic logic [VEC_W-1:0] form_vec(
    input logic [VEC_W-1:0] base, input logic with_stat,
    input logic e, input logic p);
    return with_stat ? {base[VEC_W-1:STAT_W], e, p} : base;
  endfunction

  // control register: soft reset bit dominates all other bits
  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= CTL_W'(1);
    else if (ctl_wr) begin
      if (ctl_q[0] || ctl_wdata[0])
        ctl_q <= CTL_W'(ctl_wdata[0]);
      else
        ctl_q <= ctl_wdata;
    end
  end

  assign ctl_rdata = ctl_q;
  assign clr       = ctl_q[0] | (ctl_wr & ctl_wdata[0]);
  assign mie       = ctl_q[MIE_BIT];
  assign vis       = ctl_q[NUM_SRC:1];

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      icu_src_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .event_i  (src_event[g]),
        .cmd_hit  (cmd_valid && cmd_sel == SEL_W'(g)),
        .cmd_code (icu_cmd_e'(cmd_code)),
        .ack_hit  (ack && win[g]),
        .ip       (ip_v[g]),
        .ius      (ius_v[g]),
        .ie       (ie_v[g]),
        .err      (err_v[g])
      );
    end
  endgenerate

  icu_prio #(.N(NUM_SRC), .IDX_W(SEL_W)) u_prio (
    .ip      (ip_v),
    .ie      (ie_v),
    .ius     (ius_v),
    .win     (win),
    .win_idx (win_idx),
    .win_any (win_any)
  );

  icu_vec_bank #(.N(NUM_SRC), .VEC_W(VEC_W), .SEL_W(SEL_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (vec_wr),
    .wr_sel    (vec_wsel),
    .wr_data   (vec_wdata),
    .rd_sel_a  (vec_rsel),
    .rd_data_a (base_rd),
    .rd_sel_b  (win_idx),
    .rd_data_b (base_cur)
  );

  // status bits of the addressed source
  logic rd_vis, rd_err, rd_ip, cur_vis, cur_err, cur_ip;
  always_comb begin
    rd_vis = 1'b0; rd_err = 1'b0; rd_ip = 1'b0;
    cur_vis = 1'b0; cur_err = 1'b0; cur_ip = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (vec_rsel == SEL_W'(i)) begin
        rd_vis = vis[i]; rd_err = err_v[i]; rd_ip = ip_v[i];
      end
      if (win_idx == SEL_W'(i)) begin
        cur_vis = vis[i]; cur_err = err_v[i]; cur_ip = ip_v[i];
      end
    end
  end

  assign cur_vec = win_any ? form_vec(base_cur, mie & cur_vis, cur_err, cur_ip)
                           : {VEC_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_rdata <= '0;
      irq_n     <= 1'b1;
    end else begin
      if (vec_rd)
        vec_rdata <= form_vec(base_rd, mie & rd_vis, rd_err, rd_ip);
      irq_n <= ~(mie & win_any);
    end
  end

  // R4: the request line only drops when the master enable was on
  a_r4_irq_needs_mie: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(mie));

  // R8: acknowledge marks the winning source in service
  a_r8_ack_sets_ius: assert property (@(posedge clk) disable iff (rst)
    (ack && win_any && !clr) |=> ((ius_v & $past(win)) == $past(win)));

  // R9: soft reset keeps every source flag clear
  a_r9_reset_empty: assert property (@(posedge clk) disable iff (rst)
    ctl_q[0] |-> (ip_v == '0 && ius_v == '0 && ie_v == '0 && err_v == '0));

endmodule

// File: tb/icu_top_test.sv
module icu_top_test;

  localparam int CLK_P = 10;
  localparam int N = 5;
  localparam int SW = 3;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  src_event;
  logic          cmd_valid;
  logic [SW-1:0] cmd_sel;
  logic [2:0]    cmd_code;
  logic          ack;
  logic          ctl_wr;
  logic [CW-1:0] ctl_wdata;
  logic [CW-1:0] ctl_rdata;
  logic          vec_wr;
  logic [SW-1:0] vec_wsel;
  logic [7:0]    vec_wdata;
  logic          vec_rd;
  logic [SW-1:0] vec_rsel;
  logic [7:0]    vec_rdata;
  logic [7:0]    cur_vec;
  logic          irq_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  icu_top uut (
    .clk(clk), .rst(rst), .src_event(src_event), .cmd_valid(cmd_valid),
    .cmd_sel(cmd_sel), .cmd_code(cmd_code), .ack(ack), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .vec_wr(vec_wr),
    .vec_wsel(vec_wsel), .vec_wdata(vec_wdata), .vec_rd(vec_rd),
    .vec_rsel(vec_rsel), .vec_rdata(vec_rdata), .cur_vec(cur_vec), .irq_n(irq_n)
  );

  // row: {kind(0 cmd,1 event,2 ack), src, code, expected cur_vec, expected irq_n}
  localparam logic [16:0] TBL [0:14] = '{
    {2'd1, 3'd2, 3'd0, 8'hFF, 1'b1},
    {2'd0, 3'd2, 3'd6, 8'h31, 1'b0},
    {2'd1, 3'd2, 3'd0, 8'h33, 1'b0},
    {2'd0, 3'd4, 3'd6, 8'h33, 1'b0},
    {2'd0, 3'd4, 3'd4, 8'h33, 1'b0},
    {2'd1, 3'd0, 3'd0, 8'h33, 1'b0},
    {2'd0, 3'd0, 3'd6, 8'h11, 1'b0},
    {2'd2, 3'd0, 3'd0, 8'hFF, 1'b1},
    {2'd0, 3'd0, 3'd1, 8'h33, 1'b0},
    {2'd0, 3'd2, 3'd5, 8'h51, 1'b0},
    {2'd0, 3'd4, 3'd2, 8'hFF, 1'b1},
    {2'd0, 3'd4, 3'd3, 8'h51, 1'b0},
    {2'd0, 3'd4, 3'd7, 8'hFF, 1'b1},
    {2'd0, 3'd4, 3'd0, 8'hFF, 1'b1},
    {2'd0, 3'd4, 3'd6, 8'h51, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_cmd(input int s, input int c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = SW'(s); cmd_code = 3'(c);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_event(input int s);
    @(negedge clk);
    src_event = N'(1) << s;
    @(negedge clk);
    src_event = '0;
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [CW-1:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic vec_write(input int s, input logic [7:0] d);
    @(negedge clk);
    vec_wr = 1'b1; vec_wsel = SW'(s); vec_wdata = d;
    @(negedge clk);
    vec_wr = 1'b0;
  endtask

  task automatic vec_read(input int s, output logic [7:0] d);
    @(negedge clk);
    vec_rd = 1'b1; vec_rsel = SW'(s);
    @(negedge clk);
    vec_rd = 1'b0;
    d = vec_rdata;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst = 1'b1; src_event = '0; cmd_valid = 1'b0; cmd_sel = '0; cmd_code = '0;
    ack = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; vec_wr = 1'b0; vec_wsel = '0;
    vec_wdata = '0; vec_rd = 1'b0; vec_rsel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R7 reset ctl", ctl_rdata, 7'h01);
    check("R5 reset cur_vec", cur_vec, 8'hFF);
    check("R4 reset irq_n", irq_n, 1);
    vec_read(0, rd);
    check("R10 reset base", rd, 8'h00);

    // soft reset held: other bits ignored
    ctl_write(7'h7F);
    check("R7 write in reset", ctl_rdata, 7'h01);
    ctl_write(7'h00);
    check("R7 release", ctl_rdata, 7'h00);

    for (int i = 0; i < N; i++) vec_write(i, 8'((i + 1) * 16));
    vec_read(1, rd);
    check("R10 R6 base no mie", rd, 8'h20);
    ctl_write(7'h7E);
    check("R7 ctl load", ctl_rdata, 7'h7E);

    // table walk
    for (int r = 0; r < 15; r++) begin
      logic [16:0] row;
      row = TBL[r];
      case (row[16:15])
        2'd0: do_cmd(int'(row[14:12]), int'(row[11:9]));
        2'd1: do_event(int'(row[14:12]));
        default: begin
          @(negedge clk); ack = 1'b1;
          @(negedge clk); ack = 1'b0;
          @(negedge clk);
        end
      endcase
      check($sformatf("R1 R2 R3 R5 R8 row %0d cur_vec", r), cur_vec, row[8:1]);
      check($sformatf("R3 R4 row %0d irq_n", r), irq_n, row[0]);
    end

    // R6 status merge and its gating
    vec_read(4, rd);
    check("R6 status merged", rd, 8'h51);
    ctl_write(7'h5E);
    vec_read(4, rd);
    check("R6 status bit off", rd, 8'h50);
    check("R5 cur_vec status off", cur_vec, 8'h50);
    ctl_write(7'h3E);
    settle();
    check("R4 irq_n with mie off", irq_n, 1);
    vec_read(4, rd);
    check("R6 mie off raw base", rd, 8'h50);
    check("R5 cur_vec mie off", cur_vec, 8'h50);
    ctl_write(7'h7E);

    // R8 acknowledge returns vector in its own cycle
    @(negedge clk);
    ack = 1'b1;
    #1;
    check("R8 ack vector", cur_vec, 8'h51);
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
    check("R8 after ack cur_vec", cur_vec, 8'hFF);
    check("R8 R3 after ack irq_n", irq_n, 1);

    // R2 clear beats same-cycle event
    do_cmd(3, 6);
    @(negedge clk);
    src_event = N'(1) << 3; cmd_valid = 1'b1; cmd_sel = 3'd3; cmd_code = 3'd5;
    @(negedge clk);
    src_event = '0; cmd_valid = 1'b0;
    @(negedge clk);
    check("R2 clear wins over event", cur_vec, 8'hFF);

    // R9 soft reset swallows events and commands
    ctl_write(7'h01);
    check("R7 soft reset reads one", ctl_rdata, 7'h01);
    do_event(1);
    do_cmd(1, 6);
    check("R9 cur_vec in reset", cur_vec, 8'hFF);
    check("R9 irq_n in reset", irq_n, 1);
    ctl_write(7'h7E);
    check("R7 release ignores other bits", ctl_rdata, 7'h00);
    ctl_write(7'h7E);
    do_cmd(1, 6);
    settle();
    check("R9 event in reset dropped", cur_vec, 8'hFF);
    do_cmd(1, 4);
    check("R1 set pending after release", cur_vec, 8'h21);
    vec_read(1, rd);
    check("R10 R6 base kept", rd, 8'h21);
    check("R4 irq_n low", irq_n, 0);

    ctl_write(7'h7F);
    check("R7 enter reset from run", ctl_rdata, 7'h01);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule